// File: doc/BRIEF.md
# Indexed peripheral clock control register

This block is a single 32-bit control word that reaches the clock settings of up to 64 peripheral slots through one address. Each bus write carries a slot index and a command bit. A write with the command bit clear only points the readback at a slot. A write with the command bit set also stores the written clock fields into that slot.

Each real slot holds five fields: a 3-bit generated-clock source code, an 8-bit generated-clock divider, a 2-bit peripheral-clock divider, a peripheral clock enable and a generated clock enable. All slots drive their settings in parallel on flat export buses to the clock generators, which sit outside this block. Software changes one field with a read-modify-write sequence. It first writes the index with the command bit clear, then reads the word, and then writes it back with the command bit set.

Top module: `periph_clk_index_reg`

## Requirements
- R1: After reset, every slot has both enables at 0, source code 0 and both dividers 0, the readback index is 0, and `rd_data` reads 0.
- R2: A write with bit 12 clear changes no slot's stored fields or exported settings.
- R3: A write with bit 12 set and index (bits 5:0) in 2..63 stores bits 10:8 as source code, 17:16 as peripheral divider, 27:20 as generated divider, 28 as peripheral enable and 29 as generated enable into that slot, and the slot's export buses show them from the next cycle.
- R4: `rd_data` returns the latched index in bits 5:0 and the selected slot's fields at the same bit positions used for writing.
- R5: A commit write to index 0 or 1 has no effect on any slot, and reading those indices returns every field as 0.
- R6: Bit 12 and all bits outside 5:0, 10:8, 17:16, 27:20, 28 and 29 always read as 0, whatever was written.
- R7: A source code of 6 or 7 is stored and read back as written, but that slot's `gsrc_valid_o` bit is 0; codes 0 to 5 give 1.
- R8: Every write, commit or not, latches its index for readback from the next cycle.
- R9: A commit to one slot leaves every other slot's settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Written control word |
| rd_data | output | 32 | Readback of the selected slot |
| gsrc_o | output | 192 | Per-slot generated-clock source code, 3 bits per slot |
| gsrc_valid_o | output | 64 | Per-slot flag: source code names a real source |
| gdiv_o | output | 512 | Per-slot generated-clock divider, 8 bits per slot |
| pdiv_o | output | 128 | Per-slot peripheral divider, 2 bits per slot |
| pclk_en_o | output | 64 | Per-slot peripheral clock enable |
| gclk_en_o | output | 64 | Per-slot generated clock enable |

## Verification
A wrong slot decode or a leaked commit shows up at once on the export buses. The wrong slot changes its settings in the cycle after the write, even though that slot is never read back. A wrong readback index or a bad field position shows in `rd_data` one cycle after the write that selects the slot. Because of this, every stimulus vector is read back through the selecting write and also checked on the export buses. Corruption of a slot that has not been touched can stay hidden until that slot is read. For this reason the bench compares the full export buses before and after writes with the command bit clear.

// File: rtl/periph_clk_index_reg.sv
module periph_clk_index_reg #(
  parameter int NSLOT         = 64,
  parameter int FIRST_REAL    = 2,
  parameter int DATA_W        = 32,
  parameter int SRC_W         = 3,
  parameter int SRC_VALID_MAX = 5,
  parameter int GDIV_W        = 8,
  parameter int PDIV_W        = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NSLOT*SRC_W-1:0]    gsrc_o,
  output logic [NSLOT-1:0]          gsrc_valid_o,
  output logic [NSLOT*GDIV_W-1:0]   gdiv_o,
  output logic [NSLOT*PDIV_W-1:0]   pdiv_o,
  output logic [NSLOT-1:0]          pclk_en_o,
  output logic [NSLOT-1:0]          gclk_en_o
);

  localparam int IDX_W    = $clog2(NSLOT);
  localparam int SRC_LSB  = 8;
  localparam int CMD_BIT  = 12;
  localparam int PDIV_LSB = 16;
  localparam int GDIV_LSB = 20;
  localparam int PEN_BIT  = 28;
  localparam int GEN_BIT  = 29;
  localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'((1 << IDX_W) - 1))
    | (DATA_W'((1 << SRC_W) - 1) << SRC_LSB)
    | (DATA_W'((1 << PDIV_W) - 1) << PDIV_LSB)
    | (DATA_W'((1 << GDIV_W) - 1) << GDIV_LSB)
    | (DATA_W'(1) << PEN_BIT)
    | (DATA_W'(1) << GEN_BIT);

  logic [IDX_W-1:0] wr_idx, sel_q;
  logic             commit;

  assign wr_idx = wr_data[IDX_W-1:0];
  assign commit = wr_en && wr_data[CMD_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_idx;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < FIRST_REAL) begin : g_none
      assign gsrc_o[s*SRC_W +: SRC_W]    = '0;
      assign gdiv_o[s*GDIV_W +: GDIV_W]  = '0;
      assign pdiv_o[s*PDIV_W +: PDIV_W]  = '0;
      assign pclk_en_o[s]                = 1'b0;
      assign gclk_en_o[s]                = 1'b0;
    end else begin : g_real
      logic [SRC_W-1:0]  src_q;
      logic [GDIV_W-1:0] gdiv_q;
      logic [PDIV_W-1:0] pdiv_q;
      logic              pen_q, gen_q;
      logic              hit;

      assign hit = commit && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          src_q  <= '0;
          gdiv_q <= '0;
          pdiv_q <= '0;
          pen_q  <= 1'b0;
          gen_q  <= 1'b0;
        end else if (hit) begin
          src_q  <= wr_data[SRC_LSB +: SRC_W];
          gdiv_q <= wr_data[GDIV_LSB +: GDIV_W];
          pdiv_q <= wr_data[PDIV_LSB +: PDIV_W];
          pen_q  <= wr_data[PEN_BIT];
          gen_q  <= wr_data[GEN_BIT];
        end

      assign gsrc_o[s*SRC_W +: SRC_W]    = src_q;
      assign gdiv_o[s*GDIV_W +: GDIV_W]  = gdiv_q;
      assign pdiv_o[s*PDIV_W +: PDIV_W]  = pdiv_q;
      assign pclk_en_o[s]                = pen_q;
      assign gclk_en_o[s]                = gen_q;
    end
    assign gsrc_valid_o[s] = gsrc_o[s*SRC_W +: SRC_W] <= SRC_W'(SRC_VALID_MAX);
  end

  always_comb begin
    rd_data                          = '0;
    rd_data[IDX_W-1:0]               = sel_q;
    rd_data[SRC_LSB +: SRC_W]        = gsrc_o[sel_q*SRC_W +: SRC_W];
    rd_data[PDIV_LSB +: PDIV_W]      = pdiv_o[sel_q*PDIV_W +: PDIV_W];
    rd_data[GDIV_LSB +: GDIV_W]      = gdiv_o[sel_q*GDIV_W +: GDIV_W];
    rd_data[PEN_BIT]                 = pclk_en_o[sel_q];
    rd_data[GEN_BIT]                 = gclk_en_o[sel_q];
  end

  a_r2_select_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CMD_BIT]) |=> ($stable(gsrc_o) && $stable(gdiv_o) && $stable(pdiv_o)
                                      && $stable(pclk_en_o) && $stable(gclk_en_o)));

  a_r3_commit_reads_back: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_idx >= IDX_W'(FIRST_REAL)) |=>
      (rd_data[GDIV_LSB +: GDIV_W] == $past(wr_data[GDIV_LSB +: GDIV_W])
       && rd_data[PEN_BIT] == $past(wr_data[PEN_BIT])
       && rd_data[GEN_BIT] == $past(wr_data[GEN_BIT])));

  a_r5_low_slots_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en_o[FIRST_REAL-1:0] == '0 && gclk_en_o[FIRST_REAL-1:0] == '0));

  a_r6_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & ~USED_MASK) == '0));

  a_r8_index_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[IDX_W-1:0] == $past(wr_idx));

endmodule

// File: tb/periph_clk_index_reg_test.sv
module periph_clk_index_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [191:0] gsrc_o;
  logic [63:0]  gsrc_valid_o;
  logic [511:0] gdiv_o;
  logic [127:0] pdiv_o;
  logic [63:0]  pclk_en_o, gclk_en_o;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  periph_clk_index_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .gsrc_o(gsrc_o), .gsrc_valid_o(gsrc_valid_o), .gdiv_o(gdiv_o), .pdiv_o(pdiv_o),
    .pclk_en_o(pclk_en_o), .gclk_en_o(gclk_en_o)
  );

  function automatic logic [31:0] mk(int idx, bit cmd, int src, int pdiv, int gdiv, bit pen, bit gen);
    logic [31:0] w = '0;
    w[5:0]   = idx[5:0];
    w[12]    = cmd;
    w[10:8]  = src[2:0];
    w[17:16] = pdiv[1:0];
    w[27:20] = gdiv[7:0];
    w[28]    = pen;
    w[29]    = gen;
    return w;
  endfunction

  localparam int NV = 9;
  localparam logic [31:0] SPARE = 32'hC00C_E8C0;
  localparam logic [31:0] WR [NV] = '{
    mk(5, 1, 3, 2, 8'hA5, 1, 1),
    mk(63, 1, 7, 1, 8'hFF, 0, 1),
    mk(5, 0, 1, 0, 8'h11, 0, 0),
    mk(1, 1, 2, 3, 8'h33, 1, 1),
    mk(2, 1, 6, 3, 8'h00, 1, 0),
    mk(63, 0, 0, 0, 0, 0, 0),
    mk(0, 1, 7, 3, 8'hFF, 1, 1),
    mk(9, 0, 5, 1, 8'h42, 1, 0),
    mk(10, 1, 4, 0, 8'h7E, 0, 0) | SPARE
  };
  localparam logic [31:0] EXP [NV] = '{
    mk(5, 0, 3, 2, 8'hA5, 1, 1),
    mk(63, 0, 7, 1, 8'hFF, 0, 1),
    mk(5, 0, 3, 2, 8'hA5, 1, 1),
    mk(1, 0, 0, 0, 0, 0, 0),
    mk(2, 0, 6, 3, 8'h00, 1, 0),
    mk(63, 0, 7, 1, 8'hFF, 0, 1),
    mk(0, 0, 0, 0, 0, 0, 0),
    mk(9, 0, 0, 0, 0, 0, 0),
    mk(10, 0, 4, 0, 8'h7E, 0, 0)
  };
  localparam string TAG [NV] = '{"R3", "R7", "R2", "R5", "R7", "R4", "R5", "R8", "R6"};

  task automatic check(string req, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [191:0] src_snap;
    logic [511:0] gdiv_snap;
    logic [63:0]  en_snap;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 enables", {pclk_en_o, gclk_en_o}, 0);
    check("R1 dividers", {gdiv_o, pdiv_o, gsrc_o}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_write(WR[i]);
      check(TAG[i], rd_data, EXP[i]);
    end

    // R3: exported settings of committed slot 5
    check("R3 gdiv slot5", gdiv_o[5*8 +: 8], 8'hA5);
    check("R3 pdiv slot5", pdiv_o[5*2 +: 2], 2'd2);
    check("R3 src slot5", gsrc_o[5*3 +: 3], 3'd3);
    check("R3 enables slot5", {pclk_en_o[5], gclk_en_o[5]}, 2'b11);
    // R7: source validity
    check("R7 valid slot63", gsrc_valid_o[63], 1'b0);
    check("R7 valid slot2", gsrc_valid_o[2], 1'b0);
    check("R7 valid slot5", gsrc_valid_o[5], 1'b1);
    check("R7 valid slot10", gsrc_valid_o[10], 1'b1);
    // R5: low slots untouched at the ports
    check("R5 slot0/1 exports", {gdiv_o[15:0], gsrc_o[5:0], pdiv_o[3:0], pclk_en_o[1:0], gclk_en_o[1:0]}, 0);

    // R2: select writes leave every slot unchanged
    src_snap = gsrc_o; gdiv_snap = gdiv_o; en_snap = pclk_en_o ^ {gclk_en_o[62:0], 1'b0};
    do_write(mk(33, 0, 7, 3, 8'hFF, 1, 1));
    do_write(mk(5, 0, 0, 0, 0, 0, 0));
    check("R2 gsrc stable", gsrc_o, src_snap);
    check("R2 gdiv stable", gdiv_o, gdiv_snap);
    check("R2 enables stable", pclk_en_o ^ {gclk_en_o[62:0], 1'b0}, en_snap);

    // R9: commit to slot 6 leaves slot 5 and slot 63 unchanged
    do_write(mk(6, 1, 1, 1, 8'h01, 1, 0));
    check("R9 slot6 readback", rd_data, mk(6, 0, 1, 1, 8'h01, 1, 0));
    do_write(mk(5, 0, 0, 0, 0, 0, 0));
    check("R9 slot5 unchanged", rd_data, mk(5, 0, 3, 2, 8'hA5, 1, 1));
    check("R9 slot63 gdiv", gdiv_o[63*8 +: 8], 8'hFF);

    // R8: read-modify-write of the generated divider through a commit
    do_write(rd_data | 32'h0000_1000 | 32'h0010_0000);
    check("R8 rmw readback", rd_data, mk(5, 0, 3, 2, 8'hA5 | 8'h01, 1, 1));

    // R1: reset again clears slots and index
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset clears rd", rd_data, 0);
    check("R1 reset clears exports", {gdiv_o, pclk_en_o, gclk_en_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule